// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Controller

This block is the slave-side power-mode logic of a serial-interface memory. It watches the serial clock, the active-low chip select and the serial data input, collects an 8-bit command while chip select is low, and acts on two commands: enter deep power-down and release from deep power-down. After a release command it returns a fixed identification byte on the serial output for as long as chip select stays low. Leaving deep power-down is not instant. A wake-up timer of a set number of system clock cycles holds the ready flag low, and any command started during that interval is discarded.

All serial pins are resynchronised into the system clock domain, and their edges are detected there. The serial clock must therefore run well below the system clock. A central state machine tracks the mode. Its states are ST_STANDBY (idle and ready), ST_RECV (collecting a byte in standby), ST_PD_ARM (power-down byte seen, waiting for chip select to rise), ST_SKIP (command ignored until chip select rises), ST_DOWN (deep power-down), ST_DOWN_RECV (collecting a byte while down), ST_DOWN_SKIP (non-release byte while down), ST_SEND_ID (identification byte going out) and ST_WAKE (wake-up delay).

The transitions are as follows:
- Chip select falling moves ST_STANDBY to ST_RECV and ST_DOWN to ST_DOWN_RECV.
- Chip select rising before a whole byte returns ST_RECV to ST_STANDBY and ST_DOWN_RECV to ST_DOWN.
- A completed byte in ST_RECV goes to ST_PD_ARM for the power-down code, to ST_SEND_ID for the release code, and to ST_SKIP for any other code.
- A completed byte in ST_DOWN_RECV goes to ST_SEND_ID for the release code and to ST_DOWN_SKIP for any other code.
- In ST_PD_ARM, chip select rising goes to ST_DOWN when exactly 8 bits arrived, and to ST_STANDBY otherwise.
- Chip select rising returns ST_SKIP to ST_STANDBY and ST_DOWN_SKIP to ST_DOWN.
- Chip select rising leaves ST_SEND_ID for ST_WAKE when the release was issued from power-down, and for ST_STANDBY otherwise.
- When the timer expires, ST_WAKE goes to ST_STANDBY if chip select is high, and to ST_SKIP if chip select is low.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: After reset, ready is 1, pd_flag is 0, and so is high-impedance.
- R2: Command bits are taken on rising serial clock edges while cs_n is low, most significant bit first. The power-down code 0xB9, followed by cs_n rising after exactly 8 bits, sets pd_flag to 1 and ready to 0. Any code other than 0xB9 or 0xAB received in standby leaves the mode unchanged.
- R3: A power-down code sent with 7 bits, or followed by a 9th bit, is ignored, and the block stays in standby.
- R4: While powered down, every code other than the release code 0xAB, including 0xB9, is ignored and pd_flag stays 1.
- R5: After the 8th bit of the release code 0xAB, the identification byte (parameter, default 0x12) is driven on so. It goes out most significant bit first, with each bit changing on a falling serial clock edge, starting at the falling edge that follows the 8th command bit. It repeats every 8 serial clocks while cs_n stays low.
- R6: so is high-impedance whenever cs_n is high.
- R7: A release from power-down clears pd_flag when cs_n rises. ready then stays 0 for WAKE_CYCLES system clock cycles before it returns to 1. ready and pd_flag are never both 1.
- R8: A release from power-down that is cut short, with cs_n rising after the command byte but before the identification byte completes, still returns the block to standby after the wake-up delay.
- R9: A command started while the wake-up delay is running is ignored, even if it is the power-down code.
- R10: A release code received in standby returns the identification byte and leaves ready at 1, with no wake-up delay.
- R11: A release code cut off before its 8th bit while powered down is discarded, and the block stays powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output, high-impedance when not sending |
| ready | output | 1 | 1 when in standby and able to accept commands |
| pd_flag | output | 1 | 1 while in deep power-down |

## Verification
A table of command sequences starts from standby and covers three cases. It sends the power-down code with 7, 8 and 9 bits, which separates the exact-count rule from plain code matching. It then sends foreign codes, a second power-down and a truncated release while the block is down, which shows that only a complete release is honoured. Directed sequences read the identification byte over two repetitions, both from standby and from power-down, to tell the no-delay path from the timed path. Further directed sequences sample ready just before and just after the wake-up window, and start a power-down command inside that window to show it is dropped.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [3:0] {
        ST_STANDBY,
        ST_RECV,
        ST_PD_ARM,
        ST_SKIP,
        ST_DOWN,
        ST_DOWN_RECV,
        ST_DOWN_SKIP,
        ST_SEND_ID,
        ST_WAKE
    } fpc_state_e;

    localparam int CMD_BITS = 8;

endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] prev;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
            end
        end

        assign dout[b] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= RST_VAL;
        end else begin
            prev <= dout;
        end
    end

    assign rise = dout & ~prev;
    assign fall = ~dout & prev;

endmodule

// File: rtl/fpc_rx.sv
module fpc_rx
    import fpc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck_rise,
    input  logic                cs_fall,
    input  logic                cs_low,
    input  logic                sdi,
    output logic                cmd_valid,
    output logic [CMD_BITS-1:0] cmd,
    output logic [CNT_W-1:0]    bit_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CMD_BITS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            cmd       <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (cs_fall) begin
                bit_cnt <= '0;
            end else if (sck_rise && cs_low) begin
                cmd <= {cmd[CMD_BITS-2:0], sdi};
                if (bit_cnt != CNT_MAX) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
                cmd_valid <= (bit_cnt == LAST_BIT);
            end
        end
    end

    assert_byte_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (bit_cnt == CNT_W'(CMD_BITS)));

endmodule

// File: rtl/fpc_tx.sv
module fpc_tx
    import fpc_pkg::*;
#(
    parameter logic [CMD_BITS-1:0] ID_BYTE = 8'h12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sck_fall,
    output logic so_bit,
    output logic so_en
);

    localparam int IDX_W = $clog2(CMD_BITS);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            so_bit <= 1'b0;
            so_en  <= 1'b0;
        end else if (!active) begin
            idx    <= '0;
            so_en  <= 1'b0;
        end else if (sck_fall) begin
            so_bit <= ID_BYTE[CMD_BITS-1-int'(idx)];
            idx    <= idx + 1'b1;
            so_en  <= 1'b1;
        end
    end

    assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !so_en);

endmodule

// File: rtl/fpc_wake_timer.sv
module fpc_wake_timer #(
    parameter int WAKE_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    assert_load_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);

endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
    import fpc_pkg::*;
#(
    parameter logic [7:0] CMD_PD      = 8'hB9,
    parameter logic [7:0] CMD_RES     = 8'hAB,
    parameter logic [7:0] ID_BYTE     = 8'h12,
    parameter int         WAKE_CYCLES = 40,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so,
    output logic ready,
    output logic pd_flag
);

    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(CMD_BITS);

    fpc_state_e state, state_nx;
    logic       from_down, from_down_nx;

    logic [2:0] pin_sync, pin_rise, pin_fall;
    logic       s_sck_rise, s_sck_fall, s_cs_n, s_cs_rise, s_cs_fall, s_si;

    logic                cmd_valid;
    logic [CMD_BITS-1:0] cmd;
    logic [CNT_W-1:0]    bit_cnt;

    logic so_bit, so_en, tx_active;
    logic wake_load, wake_done;

    fpc_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({si, cs_n, sck}),
        .dout  (pin_sync),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign s_sck_rise = pin_rise[0];
    assign s_sck_fall = pin_fall[0];
    assign s_cs_n     = pin_sync[1];
    assign s_cs_rise  = pin_rise[1];
    assign s_cs_fall  = pin_fall[1];
    assign s_si       = pin_sync[2];

    fpc_rx #(
        .CNT_W (CNT_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (s_sck_rise),
        .cs_fall   (s_cs_fall),
        .cs_low    (!s_cs_n),
        .sdi       (s_si),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .bit_cnt   (bit_cnt)
    );

    fpc_tx #(
        .ID_BYTE (ID_BYTE)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (tx_active),
        .sck_fall (s_sck_fall),
        .so_bit   (so_bit),
        .so_en    (so_en)
    );

    fpc_wake_timer #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wake_load),
        .done  (wake_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_STANDBY;
            from_down <= 1'b0;
        end else begin
            state     <= state_nx;
            from_down <= from_down_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx     = state;
        from_down_nx = from_down;
        unique case (state)
            ST_STANDBY: begin
                if (s_cs_fall) state_nx = ST_RECV;
            end
            ST_RECV: begin
                if (s_cs_rise) begin
                    state_nx = ST_STANDBY;
                end else if (cmd_valid) begin
                    if (cmd == CMD_PD) begin
                        state_nx = ST_PD_ARM;
                    end else if (cmd == CMD_RES) begin
                        state_nx     = ST_SEND_ID;
                        from_down_nx = 1'b0;
                    end else begin
                        state_nx = ST_SKIP;
                    end
                end
            end
            ST_PD_ARM: begin
                if (s_cs_rise) begin
                    state_nx = (bit_cnt == FULL_BYTE) ? ST_DOWN : ST_STANDBY;
                end
            end
            ST_SKIP: begin
                if (s_cs_rise) state_nx = ST_STANDBY;
            end
            ST_DOWN: begin
                if (s_cs_fall) state_nx = ST_DOWN_RECV;
            end
            ST_DOWN_RECV: begin
                if (s_cs_rise) begin
                    state_nx = ST_DOWN;
                end else if (cmd_valid) begin
                    if (cmd == CMD_RES) begin
                        state_nx     = ST_SEND_ID;
                        from_down_nx = 1'b1;
                    end else begin
                        state_nx = ST_DOWN_SKIP;
                    end
                end
            end
            ST_DOWN_SKIP: begin
                if (s_cs_rise) state_nx = ST_DOWN;
            end
            ST_SEND_ID: begin
                if (s_cs_rise) begin
                    state_nx     = from_down ? ST_WAKE : ST_STANDBY;
                    from_down_nx = 1'b0;
                end
            end
            ST_WAKE: begin
                if (wake_done) begin
                    state_nx = s_cs_n ? ST_STANDBY : ST_SKIP;
                end
            end
            default: state_nx = ST_STANDBY;
        endcase
    end

    // Output logic
    always_comb begin
        ready     = 1'b0;
        pd_flag   = 1'b0;
        tx_active = 1'b0;
        wake_load = 1'b0;
        unique case (state)
            ST_STANDBY, ST_RECV, ST_PD_ARM, ST_SKIP: begin
                ready = 1'b1;
            end
            ST_DOWN, ST_DOWN_RECV, ST_DOWN_SKIP: begin
                pd_flag = 1'b1;
            end
            ST_SEND_ID: begin
                ready     = !from_down;
                pd_flag   = from_down;
                tx_active = !s_cs_n;
                wake_load = from_down && s_cs_rise;
            end
            ST_WAKE: begin
                ready = 1'b0;
            end
            default: ready = 1'b0;
        endcase
    end

    assign so = so_en ? so_bit : 1'bz;

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && pd_flag));

    assert_cs_high_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cs_n && $past(s_cs_n)) |-> !so_en);

    assert_pd_exit_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_flag) |-> (state == ST_WAKE));

    assert_pd_entry_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_flag) |-> ($past(state) == ST_PD_ARM && $past(bit_cnt) == FULL_BYTE));

    assert_ready_after_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && $past(state) == ST_WAKE) |-> $past(wake_done));

endmodule

// File: tb/flash_pwr_ctrl_tb.sv
module flash_pwr_ctrl_tb;

    localparam int  WAKE  = 40;
    localparam int  HALF  = 6;
    localparam logic [7:0] ID = 8'h12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic so, ready, pd_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_pwr_ctrl #(
        .ID_BYTE     (ID),
        .WAKE_CYCLES (WAKE)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .cs_n    (cs_n),
        .si      (si),
        .so      (so),
        .ready   (ready),
        .pd_flag (pd_flag)
    );

    // Vector: {req[3:0], nbits[3:0], data[15:0], exp_pd, exp_ready}
    localparam logic [25:0] VEC [10] = '{
        {4'd2,  4'd8, 16'h00B9, 1'b1, 1'b0},  // R2 power-down
        {4'd4,  4'd8, 16'h0003, 1'b1, 1'b0},  // R4 foreign code while down
        {4'd4,  4'd8, 16'h00B9, 1'b1, 1'b0},  // R4 repeat power-down while down
        {4'd11, 4'd7, 16'h0055, 1'b1, 1'b0},  // R11 truncated release
        {4'd8,  4'd8, 16'h00AB, 1'b0, 1'b1},  // R8 release cut short
        {4'd3,  4'd7, 16'h005C, 1'b0, 1'b1},  // R3 seven-bit power-down
        {4'd3,  4'd9, 16'h0172, 1'b0, 1'b1},  // R3 nine-bit power-down
        {4'd2,  4'd8, 16'h0005, 1'b0, 1'b1},  // R2 foreign code in standby
        {4'd2,  4'd8, 16'h00B9, 1'b1, 1'b0},  // R2 power-down again
        {4'd8,  4'd8, 16'h00AB, 1'b0, 1'b1}   // R8 release again
    };

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Shift n bits MSB first; leaves sck low; optionally keeps cs_n low
    task automatic send_bits(input logic [15:0] data, input int n, input bit keep_low);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            si = data[n-1-i];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        if (!keep_low) begin
            wait_clk(HALF);
            cs_n = 1'b1;
        end
    endtask

    task automatic read_id(input int n, input string req, input bit exp_ready);
        for (int k = 0; k < n; k++) begin
            wait_clk(HALF);
            check(so === ID[7-(k%8)], req, {7'd0, so}, {7'd0, ID[7-(k%8)]});
            check(ready === exp_ready, "R10", {7'd0, ready}, {7'd0, exp_ready});
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check(ready === 1'b1, "R1", {7'd0, ready}, 8'd1);
        check(pd_flag === 1'b0, "R1", {7'd0, pd_flag}, 8'd0);
        check(so === 1'bz, "R1", {7'd0, so}, 8'd0);

        // Vector walk (R2 R3 R4 R8 R11)
        for (int v = 0; v < 10; v++) begin
            send_bits(VEC[v][17:2], int'(VEC[v][21:18]), 1'b0);
            wait_clk(WAKE + 20);
            check(pd_flag === VEC[v][1], $sformatf("R%0d vec%0d pd", VEC[v][25:22], v),
                  {7'd0, pd_flag}, {7'd0, VEC[v][1]});
            check(ready === VEC[v][0], $sformatf("R%0d vec%0d ready", VEC[v][25:22], v),
                  {7'd0, ready}, {7'd0, VEC[v][0]});
            check(so === 1'bz, "R6", {7'd0, so}, 8'd0);
        end

        // R10 / R5: release from standby, two repetitions of the ID
        send_bits(16'h00AB, 8, 1'b1);
        read_id(16, "R5", 1'b1);
        wait_clk(5);
        check(ready === 1'b1, "R10", {7'd0, ready}, 8'd1);
        check(so === 1'bz, "R6", {7'd0, so}, 8'd0);

        // R5 / R7: power-down then release with ID readout and timed wake
        send_bits(16'h00B9, 8, 1'b0);
        wait_clk(10);
        check(pd_flag === 1'b1, "R2", {7'd0, pd_flag}, 8'd1);
        send_bits(16'h00AB, 8, 1'b1);
        read_id(8, "R5", 1'b0);
        wait_clk(8);
        check(pd_flag === 1'b0, "R7", {7'd0, pd_flag}, 8'd0);
        check(ready === 1'b0, "R7", {7'd0, ready}, 8'd0);
        wait_clk(WAKE - 13);
        check(ready === 1'b0, "R7", {7'd0, ready}, 8'd0);
        wait_clk(15);
        check(ready === 1'b1, "R7", {7'd0, ready}, 8'd1);

        // R9: power-down command started inside the wake window is dropped
        send_bits(16'h00B9, 8, 1'b0);
        wait_clk(10);
        send_bits(16'h00AB, 8, 1'b0);
        wait_clk(5);
        check(ready === 1'b0, "R9", {7'd0, ready}, 8'd0);
        send_bits(16'h00B9, 8, 1'b0);
        wait_clk(WAKE + 20);
        check(pd_flag === 1'b0, "R9", {7'd0, pd_flag}, 8'd0);
        check(ready === 1'b1, "R9", {7'd0, ready}, 8'd1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule